// File: doc/BRIEF.md
# Sector Load and Program Controller

This block sits in front of a sector-organised nonvolatile memory model. The block takes one-clock write strobes that are already synchronised and filtered. Each accepted write places a byte into a page-wide staging buffer. The first write of a cycle fixes the sector that the whole cycle works on. Later writes choose only the byte position inside that sector. They may come in any order, and they may hit the same position again.

When no further write arrives within a programmable gap, loading stops and a fixed-length program phase begins. During that phase the staged page is copied into the backing array, one byte per clock. Positions that were never written are either filled with FFh or left at their old value, depending on a keep flag sampled at the start of the cycle. The busy output is high for the whole program phase. The most recently accepted address and data are reported on dedicated outputs. A registered read port returns array contents.

All widths and times are parameters. With the defaults there are 16 sectors of 128 bytes, and the two timers equal 300 µs and 10 ms at a 125 MHz clock. The full-size device uses `SEC_W = 10`. `PROG_CYCLES` must be at least the sector size.

Top module: `sector_prog_ctrl`

## Requirements
- R1: Address bits `[SEC_W+OFS_W-1:OFS_W]` select the sector and bits `[OFS_W-1:0]` select the byte within it. With the bench parameters, address = sector*128 + offset.
- R2: The first accepted write of a load cycle latches the sector. Sector bits of later writes in the same cycle are ignored, and such a write lands in the latched sector.
- R3: Bytes may be written in any order. A position written twice holds the value of the later write after programming.
- R4: A write accepted within `GAP_CYCLES` clocks of the previous accepted write extends the load. If `GAP_CYCLES` clock edges pass after the last accepted write with no new one, busy is high from the next cycle.
- R5: With the keep flag low, every position of the sector not written during the cycle reads FFh after programming.
- R6: busy stays high for exactly `PROG_CYCLES` clocks. Write strobes during that time change neither the array nor the last-address and last-data outputs.
- R7: A write is accepted only when `ce_n`=0, `we_n`=0 and `oe_n`=1. With `oe_n` low, nothing is loaded or programmed.
- R8: With the keep flag high at the first write of a cycle, positions not written during that cycle keep their previous contents.
- R9: `last_addr` and `last_data` show the effective address (latched sector, given offset) and the data of the most recent accepted write.
- R10: After reset, busy is 0, `last_addr` and `last_data` are 0, and every array byte reads FFh.
- R11: A read (`ce_n`=0, `oe_n`=0, `we_n`=1) sampled at a clock edge puts the addressed array byte on `dout` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| addr | input | SEC_W+OFS_W | Byte address: sector bits above offset bits |
| din | input | DATA_W | Write data |
| keep_unloaded | input | 1 | Sampled at first write: 1 keeps unwritten bytes, 0 fills them with FFh |
| busy | output | 1 | High during the program phase |
| dout | output | DATA_W | Registered read data |
| last_addr | output | SEC_W+OFS_W | Effective address of the last accepted write |
| last_data | output | DATA_W | Data of the last accepted write |

## Verification
The first load writes a sector in reverse and scattered order. It overwrites one position, and its final write carries a different sector number. Afterwards the reads tell the latched sector apart from the strobed one, and the later write apart from the earlier one. A write placed exactly at the gap limit separates an extended load from a premature commit. Busy is sampled on both sides of its rising and falling edges, and a write is driven inside the program phase to show it is dropped. Two cycles reprogram the same sector, one with the keep flag high and one with it low. Comparing the untouched positions shows the difference between preserving and clearing.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [1:0] {
        SP_IDLE = 2'd0,
        SP_LOAD = 2'd1,
        SP_PROG = 2'd2
    } sp_state_e;
endpackage

// File: rtl/sp_timer.sv
module sp_timer #(
    parameter int LIMIT = 16,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    output logic [CW-1:0] cnt,
    output logic          last
);
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d.cnt = '0;
        end else if (run && s_q.cnt != TOP) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt  = s_q.cnt;
    assign last = run && !restart && (s_q.cnt == TOP);

    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= TOP);
    p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (s_q.cnt == '0));
endmodule

// File: rtl/sp_page_buf.sv
module sp_page_buf #(
    parameter int OFS_W  = 7,
    parameter int DATA_W = 8,
    localparam int PAGE  = 1 << OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_loaded
);
    typedef struct packed {
        logic [PAGE-1:0][DATA_W-1:0] data;
        logic [PAGE-1:0]             mask;
    } buf_s;

    buf_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.mask = '0;
        end
        if (wr) begin
            s_d.data[wr_ofs] = wr_data;
            s_d.mask[wr_ofs] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data   = s_q.data[rd_ofs];
    assign rd_loaded = s_q.mask[rd_ofs];

    p_clear_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && wr) |=> ($countones(s_q.mask) == 1));
    p_write_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (s_q.mask[$past(wr_ofs)] && s_q.data[$past(wr_ofs)] == $past(wr_data)));
endmodule

// File: rtl/sp_array.sv
module sp_array #(
    parameter int SEC_W  = 4,
    parameter int OFS_W  = 7,
    parameter int DATA_W = 8,
    localparam int AW    = SEC_W + OFS_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]            dout;
    } arr_s;

    arr_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            s_d.mem[waddr] = wdata;
        end
        if (rd_en) begin
            s_d.dout = s_q.mem[raddr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mem  <= '1;
            s_q.dout <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.dout;

    p_dout_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(s_q.dout));
endmodule

// File: rtl/sector_prog_ctrl.sv
module sector_prog_ctrl
    import sp_pkg::*;
#(
    parameter int SEC_W       = 4,
    parameter int OFS_W       = 7,
    parameter int DATA_W      = 8,
    parameter int GAP_CYCLES  = 37500,
    parameter int PROG_CYCLES = 1250000,
    localparam int ADDR_W     = SEC_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              keep_unloaded,
    output logic              busy,
    output logic [DATA_W-1:0] dout,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);
    localparam int PAGE = 1 << OFS_W;
    localparam int PCW  = $clog2(PROG_CYCLES + 1);
    localparam int GCW  = $clog2(GAP_CYCLES + 1);

    typedef struct packed {
        sp_state_e         st;
        logic [SEC_W-1:0]  sect;
        logic              keep;
        logic [ADDR_W-1:0] last_addr;
        logic [DATA_W-1:0] last_data;
    } ctl_s;

    ctl_s s_d, s_q;

    logic              wr_ok;
    logic              accept;
    logic              buf_clr;
    logic [GCW-1:0]    gap_cnt;
    logic              gap_last;
    logic [PCW-1:0]    prog_cnt;
    logic              prog_last;
    logic [OFS_W-1:0]  cidx;
    logic              cvalid;
    logic [DATA_W-1:0] buf_data;
    logic              buf_loaded;
    logic              arr_we;
    logic [DATA_W-1:0] arr_wdata;

    assign wr_ok = !ce_n && !we_n && oe_n;

    always_comb begin
        s_d     = s_q;
        accept  = 1'b0;
        buf_clr = 1'b0;
        unique case (s_q.st)
            SP_IDLE: begin
                if (wr_ok) begin
                    accept      = 1'b1;
                    buf_clr     = 1'b1;
                    s_d.st      = SP_LOAD;
                    s_d.sect    = addr[ADDR_W-1:OFS_W];
                    s_d.keep    = keep_unloaded;
                    s_d.last_addr = addr;
                    s_d.last_data = din;
                end
            end
            SP_LOAD: begin
                if (wr_ok) begin
                    accept        = 1'b1;
                    s_d.last_addr = {s_q.sect, addr[OFS_W-1:0]};
                    s_d.last_data = din;
                end else if (gap_last) begin
                    s_d.st = SP_PROG;
                end
            end
            SP_PROG: begin
                if (prog_last) begin
                    s_d.st = SP_IDLE;
                end
            end
            default: s_d.st = SP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= SP_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    sp_timer #(.LIMIT(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.st == SP_LOAD),
        .restart (accept),
        .cnt     (gap_cnt),
        .last    (gap_last)
    );

    sp_timer #(.LIMIT(PROG_CYCLES)) u_prog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.st == SP_PROG),
        .restart (s_q.st != SP_PROG),
        .cnt     (prog_cnt),
        .last    (prog_last)
    );

    assign cidx   = prog_cnt[OFS_W-1:0];
    assign cvalid = (s_q.st == SP_PROG) && (int'(prog_cnt) < PAGE);

    sp_page_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .wr        (accept),
        .wr_ofs    (addr[OFS_W-1:0]),
        .wr_data   (din),
        .rd_ofs    (cidx),
        .rd_data   (buf_data),
        .rd_loaded (buf_loaded)
    );

    assign arr_we    = cvalid && (buf_loaded || !s_q.keep);
    assign arr_wdata = buf_loaded ? buf_data : '1;

    sp_array #(.SEC_W(SEC_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr ({s_q.sect, cidx}),
        .wdata (arr_wdata),
        .rd_en (!ce_n && !oe_n && we_n),
        .raddr (addr),
        .dout  (dout)
    );

    assign busy      = (s_q.st == SP_PROG);
    assign last_addr = s_q.last_addr;
    assign last_data = s_q.last_data;

    p_sector_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SP_LOAD) |=> $stable(s_q.sect));
    p_prog_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SP_PROG) |=> ($stable(last_addr) && $stable(last_data)));
    p_oe_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |=> ($stable(last_addr) && $stable(last_data)));
    p_gap_to_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == SP_LOAD) && gap_last && !wr_ok) |=> busy);
    p_busy_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(prog_last));
    p_commit_sector_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);
endmodule

// File: tb/sim_sector_prog_ctrl.sv
module sim_sector_prog_ctrl;
    localparam int SEC_W = 4;
    localparam int OFS_W = 7;
    localparam int DW    = 8;
    localparam int AW    = SEC_W + OFS_W;
    localparam int GAP   = 16;
    localparam int PROG  = 160;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          keep = 1'b0;
    logic          busy;
    logic [DW-1:0] dout;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_data;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } rd_item_t;
    rd_item_t sb[$];
    logic rd_seen = 1'b0;

    always #4 clk = ~clk;

    sector_prog_ctrl #(
        .SEC_W(SEC_W), .OFS_W(OFS_W), .DATA_W(DW),
        .GAP_CYCLES(GAP), .PROG_CYCLES(PROG)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .keep_unloaded(keep), .busy(busy),
        .dout(dout), .last_addr(last_addr), .last_data(last_data)
    );

    function automatic logic [AW-1:0] ad(input int sec, input int ofs);
        return AW'(sec * 128 + ofs);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        rd_item_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    always @(posedge clk) rd_seen <= !ce_n && !oe_n && we_n;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11: read with no expected item, actual=%0h expected=none", dout);
            end else begin
                rd_item_t it;
                it = sb.pop_front();
                check(it.tag, 32'(dout), 32'(it.exp));
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 busy", 32'(busy), 0);
        check("R10 last_addr", 32'(last_addr), 0);
        check("R10 last_data", 32'(last_data), 0);
        rd(ad(0, 0), 8'hFF, "R10 blank array");
        rd(ad(15, 127), 8'hFF, "R10 blank array top");

        // R3 scattered order with overwrite; R2 sector change ignored
        keep = 1'b0;
        wr(ad(2, 5), 8'h11);
        wr(ad(2, 3), 8'h22);
        wr(ad(2, 0), 8'h33);
        wr(ad(2, 127), 8'h44);
        wr(ad(2, 3), 8'h55);
        wr(ad(5, 10), 8'h66);
        check("R9 R2 last_addr", 32'(last_addr), 32'(ad(2, 10)));
        check("R9 last_data", 32'(last_data), 32'h66);
        // R4 gap timing, R6 program length
        repeat (GAP - 1) @(negedge clk);
        check("R4 busy before gap end", 32'(busy), 0);
        @(negedge clk);
        check("R4 busy after gap end", 32'(busy), 1);
        wr(ad(7, 1), 8'h77);
        check("R6 write in program ignored addr", 32'(last_addr), 32'(ad(2, 10)));
        check("R6 write in program ignored data", 32'(last_data), 32'h66);
        repeat (PROG - 2) @(negedge clk);
        check("R6 busy last program cycle", 32'(busy), 1);
        @(negedge clk);
        check("R6 busy drops", 32'(busy), 0);

        rd(ad(2, 5), 8'h11, "R3 any order");
        rd(ad(2, 3), 8'h55, "R3 overwrite");
        rd(ad(2, 0), 8'h33, "R3 offset 0");
        rd(ad(2, 127), 8'h44, "R1 offset 127");
        rd(ad(2, 10), 8'h66, "R2 latched sector");
        rd(ad(5, 10), 8'hFF, "R2 strobed sector untouched");
        rd(ad(2, 1), 8'hFF, "R5 unloaded FF");
        rd(ad(2, 64), 8'hFF, "R5 unloaded FF mid");
        rd(ad(7, 1), 8'hFF, "R6 program-time write dropped");

        // R7 oe low inhibits
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = ad(3, 0); din = 8'h99;
        repeat (3) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (GAP + 2) @(negedge clk);
        check("R7 oe low no load", 32'(last_addr), 32'(ad(2, 10)));
        check("R7 oe low no program", 32'(busy), 0);
        rd(ad(3, 0), 8'hFF, "R7 oe low array untouched");

        // R8 keep unloaded, R4 write at gap boundary extends load
        keep = 1'b1;
        wr(ad(2, 5), 8'hA5);
        keep = 1'b0;
        repeat (GAP - 1) @(negedge clk);
        wr(ad(2, 6), 8'hB6);
        check("R4 boundary write accepted", 32'(last_addr), 32'(ad(2, 6)));
        check("R4 boundary no program yet", 32'(busy), 0);
        repeat (GAP + PROG + 2) @(negedge clk);
        check("R8 cycle complete", 32'(busy), 0);
        rd(ad(2, 5), 8'hA5, "R8 loaded byte");
        rd(ad(2, 6), 8'hB6, "R4 boundary byte stored");
        rd(ad(2, 0), 8'h33, "R8 kept old byte");
        rd(ad(2, 3), 8'h55, "R8 kept old byte 3");
        rd(ad(2, 127), 8'h44, "R8 kept old byte 127");
        rd(ad(2, 1), 8'hFF, "R8 kept erased byte");

        // R5 autoclear back on
        wr(ad(2, 1), 8'hC1);
        repeat (GAP + PROG + 2) @(negedge clk);
        rd(ad(2, 1), 8'hC1, "R5 loaded byte");
        rd(ad(2, 0), 8'hFF, "R5 cleared old byte");
        rd(ad(2, 5), 8'hFF, "R5 cleared old byte 5");
        rd(ad(4, 0), 8'hFF, "R1 other sector untouched");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL R11: unread items actual=%0d expected=0", sb.size());
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule